// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Engine

This block models the write path of a byte-wide nonvolatile memory. The host side is asynchronous in style: active-low chip select, output enable and write enable, a 17-bit address and an 8-bit data bus. A fast system clock samples all of these lines. Write pulses are collected into a page latch of up to 128 bytes. All bytes of one load share a single page address, which the first byte of the load fixes. A load window timer is restarted by every accepted byte. When the window expires and no pulse is open, the engine runs a programming cycle of fixed length. During that cycle it holds the ready line low, and at the end it writes every loaded byte into the array at once.

While programming runs, the host can poll the byte it wrote last. Bit 7 of that byte reads back inverted until the cycle ends. An external reset input makes the read bus float and discards an unfinished load. After that input returns high, a guard interval must pass before writes are accepted again. The storage array is a reset-free register file with a configurable number of page rows. All durations are parameters given in clock cycles.

Top module: `nvm_page_writer`

## Requirements
- R1: After the system reset `rst_n`, `ready` is 1, `dout_en` is 0 and no page load is open.
- R2: `dout_en` is 1 exactly when, at the previous rising clock edge, `hw_rst_n` was 1, `cs_n` was 0, `oe_n` was 0 and `we_n` was 1. `dout` then carries the stored byte at `addr`.
- R3: A byte write needs `oe_n` = 1 and both `cs_n` and `we_n` = 0. Its address is the one sampled in the first clock of this overlap, and its data is the last value sampled before the overlap ends. An overlap with `oe_n` = 0 writes nothing and starts no load.
- R4: `ready` falls only when a load window expires. It then stays 0 for exactly PROG_CYC clock cycles, whether 1 or 128 bytes were loaded.
- R5: Every accepted byte restarts the load window. Programming starts WINDOW_CYC cycles after the start of the last accepted byte, provided no write pulse is still open.
- R6: `addr[6:0]` selects the byte within a page and `addr[16:7]` is the page address. The first byte of a load fixes the page. A byte aimed at another page during the same load is dropped and does not restart the window.
- R7: All loaded bytes enter the array together at the end of programming. Offsets not loaded keep their old contents, and a second write to one offset within a load replaces the first.
- R8: While `ready` is 0, a read of the last written address returns that byte with bit 7 inverted and bits 6..0 true. Other addresses return the array contents. After `ready` rises, the true byte is returned.
- R9: A write pulse that starts while `ready` is 0 is ignored. It changes neither the array nor the next page load.
- R10: While `hw_rst_n` is 0, `dout_en` is 0, writes are rejected and an open load is discarded. After `hw_rst_n` rises, writes are rejected for PROTECT_CYC cycles.
- R11: The array holds STORED_PAGES page rows. A page address selects the row given by its low log2(STORED_PAGES) bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the host lines |
| rst_n | input | 1 | Asynchronous active-low system reset |
| hw_rst_n | input | 1 | Active-low external reset/protect input |
| cs_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | 17 | Byte address; bits 16..7 page, bits 6..0 offset |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data (array byte or polling value) |
| dout_en | output | 1 | Read bus drive enable; 0 means floating |
| ready | output | 1 | 1 when idle or loading, 0 while programming |

## Verification
A wrong window or programming counter shows on `ready`. Its fall or rise lands cycles away from the counted position, and a missing restart ends a multi-byte load early, one window after the first byte. A corrupt valid mask or latch stays hidden until a commit. It then appears on the next read of the untouched or overwritten offsets, so every check reads back after `ready` rises. A polling fault appears within one read during the busy phase. A latch disturbed by an ignored write appears only after the following commit.

// File: rtl/nvm_pw_pkg.sv
package nvm_pw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pw_state_e;

  // Bit-7 inversion seen by a polling read while the page is in flight.
  function automatic logic [7:0] poll_view(input logic [7:0] b);
    return {~b[7], b[6:0]};
  endfunction

  // True when a counter has reached its final value for a span of len cycles.
  function automatic logic span_last(input int unsigned cnt, input int unsigned len);
    return (cnt == len - 1);
  endfunction

endpackage

// File: rtl/nvm_bus_sampler.sv
module nvm_bus_sampler #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_rst_n,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DATA_W-1:0] s_din,
  output logic              hw_q,
  output logic              wr_level,
  output logic              wr_start,
  output logic              wr_end,
  output logic              rd_level
);

  logic cs_q, oe_q, we_q, lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      oe_q   <= 1'b1;
      we_q   <= 1'b1;
      hw_q   <= 1'b1;
      s_addr <= '0;
      s_din  <= '0;
      lvl_d  <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      oe_q   <= oe_n;
      we_q   <= we_n;
      hw_q   <= hw_rst_n;
      s_addr <= addr;
      s_din  <= din;
      lvl_d  <= wr_level;
    end
  end

  // Overlap of select and write strobe with outputs disabled.
  assign wr_level = !cs_q && !we_q && oe_q;
  // Later of the two falling edges opens the overlap.
  assign wr_start = wr_level && !lvl_d;
  // Earlier of the two rising edges closes it.
  assign wr_end   = !wr_level && lvl_d;
  assign rd_level = hw_q && !cs_q && !oe_q && we_q;

endmodule

// File: rtl/nvm_load_ctrl.sv
module nvm_load_ctrl
  import nvm_pw_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int OFF_W       = 7,
  parameter int PSEL_W      = 3,
  parameter int WINDOW_CYC  = 6000,
  parameter int PROG_CYC    = 2000000,
  parameter int PROTECT_CYC = 20000
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 hw_q,
  input  logic                                 wr_level,
  input  logic                                 wr_start,
  input  logic                                 wr_end,
  input  logic [ADDR_W-1:0]                    s_addr,
  input  logic [DATA_W-1:0]                    s_din,
  output logic                                 busy,
  output logic                                 loading,
  output logic                                 wr_accept,
  output logic                                 byte_store,
  output logic                                 commit,
  output logic [PSEL_W-1:0]                    commit_row,
  output logic [(1<<OFF_W)-1:0][DATA_W-1:0]    lat_data,
  output logic [(1<<OFF_W)-1:0]                lat_valid,
  output logic [ADDR_W-1:0]                    last_addr,
  output logic [DATA_W-1:0]                    last_data
);

  localparam int PAGE_W     = ADDR_W - OFF_W;
  localparam int WCNT_W     = $clog2(WINDOW_CYC + 2);
  localparam int PCNT_W     = $clog2(PROG_CYC + 2);
  localparam int GCNT_W     = $clog2(PROTECT_CYC + 2);

  pw_state_e           state;
  logic [WCNT_W-1:0]   win_cnt;
  logic [PCNT_W-1:0]   prog_cnt;
  logic [GCNT_W-1:0]   guard_cnt;
  logic [PAGE_W-1:0]   page_q;
  logic [OFF_W-1:0]    cur_off;
  logic [DATA_W-1:0]   data_hold;
  logic                open_q;
  logic                page_ok;
  logic                window_done;
  logic [PAGE_W-1:0]   s_page;

  assign s_page      = s_addr[ADDR_W-1:OFF_W];
  assign busy        = (state == ST_PROG);
  assign loading     = (state == ST_LOAD);
  assign page_ok     = (state == ST_IDLE) || (loading && (s_page == page_q));
  assign wr_accept   = wr_start && hw_q && (guard_cnt == '0) && !busy && page_ok;
  assign byte_store  = wr_end && open_q && hw_q;
  assign window_done = loading && !open_q && !wr_accept &&
                       span_last(int'(win_cnt), WINDOW_CYC);
  assign commit      = busy && span_last(int'(prog_cnt), PROG_CYC);
  assign commit_row  = page_q[PSEL_W-1:0];

  // Guard interval after the external reset input returns high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            guard_cnt <= '0;
    else if (!hw_q)        guard_cnt <= GCNT_W'(PROTECT_CYC);
    else if (guard_cnt != '0) guard_cnt <= guard_cnt - 1'b1;
  end

  // Load / program sequencing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      win_cnt  <= '0;
      prog_cnt <= '0;
      page_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (wr_accept) begin
            page_q  <= s_page;
            win_cnt <= '0;
            state   <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (!hw_q) begin
            state <= ST_IDLE;
          end else if (wr_accept) begin
            win_cnt <= '0;
          end else if (window_done) begin
            prog_cnt <= '0;
            state    <= ST_PROG;
          end else if (!span_last(int'(win_cnt), WINDOW_CYC)) begin
            win_cnt <= win_cnt + 1'b1;
          end
        end
        ST_PROG: begin
          if (commit) state <= ST_IDLE;
          else        prog_cnt <= prog_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Byte pulse tracking and the per-offset valid mask.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      cur_off   <= '0;
      data_hold <= '0;
      lat_valid <= '0;
      last_addr <= '0;
      last_data <= '0;
    end else begin
      if (!hw_q)           open_q <= 1'b0;
      else if (wr_accept)  open_q <= 1'b1;
      else if (wr_end)     open_q <= 1'b0;

      if (wr_accept) cur_off <= s_addr[OFF_W-1:0];
      if (wr_level && (open_q || wr_accept)) data_hold <= s_din;

      if (commit || (loading && !hw_q)) begin
        lat_valid <= '0;
      end else if (byte_store) begin
        lat_valid[cur_off] <= 1'b1;
        last_addr          <= {page_q, cur_off};
        last_data          <= data_hold;
      end
    end
  end

  // Page latch storage, no reset needed: the valid mask qualifies it.
  always_ff @(posedge clk) begin
    if (byte_store) lat_data[cur_off] <= data_hold;
  end

endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 7,
  parameter int PSEL_W = 3
) (
  input  logic                              clk,
  input  logic                              commit,
  input  logic [PSEL_W-1:0]                 commit_row,
  input  logic [(1<<OFF_W)-1:0][DATA_W-1:0] lat_data,
  input  logic [(1<<OFF_W)-1:0]             lat_valid,
  input  logic [PSEL_W+OFF_W-1:0]           rd_index,
  output logic [DATA_W-1:0]                 rd_data
);

  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int DEPTH      = 1 << (PSEL_W + OFF_W);

  logic [DATA_W-1:0] mem [DEPTH];

  // Whole-page commit: only offsets marked valid are overwritten.
  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (lat_valid[i]) mem[{commit_row, OFF_W'(i)}] <= lat_data[i];
      end
    end
  end

  assign rd_data = mem[rd_index];

endmodule

// File: rtl/nvm_page_writer.sv
module nvm_page_writer
  import nvm_pw_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 8,
  parameter int OFF_W        = 7,
  parameter int STORED_PAGES = 8,
  parameter int WINDOW_CYC   = 6000,
  parameter int PROG_CYC     = 2000000,
  parameter int PROTECT_CYC  = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_rst_n,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              ready
);

  localparam int PSEL_W     = $clog2(STORED_PAGES);
  localparam int PAGE_BYTES = 1 << OFF_W;

  logic [ADDR_W-1:0]                 s_addr;
  logic [DATA_W-1:0]                 s_din;
  logic                              hw_q, wr_level, wr_start, wr_end, rd_level;
  logic                              busy_w, loading_w, accept_w, store_w, commit_w;
  logic [PSEL_W-1:0]                 commit_row;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] lat_data;
  logic [PAGE_BYTES-1:0]             lat_valid;
  logic [ADDR_W-1:0]                 last_addr;
  logic [DATA_W-1:0]                 last_data;
  logic [DATA_W-1:0]                 arr_data;
  logic                              poll_hit;

  nvm_bus_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n),
    .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .din(din),
    .s_addr(s_addr), .s_din(s_din), .hw_q(hw_q),
    .wr_level(wr_level), .wr_start(wr_start), .wr_end(wr_end), .rd_level(rd_level)
  );

  nvm_load_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .PSEL_W(PSEL_W),
    .WINDOW_CYC(WINDOW_CYC), .PROG_CYC(PROG_CYC), .PROTECT_CYC(PROTECT_CYC)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .hw_q(hw_q),
    .wr_level(wr_level), .wr_start(wr_start), .wr_end(wr_end),
    .s_addr(s_addr), .s_din(s_din),
    .busy(busy_w), .loading(loading_w), .wr_accept(accept_w),
    .byte_store(store_w), .commit(commit_w), .commit_row(commit_row),
    .lat_data(lat_data), .lat_valid(lat_valid),
    .last_addr(last_addr), .last_data(last_data)
  );

  nvm_cell_array #(.DATA_W(DATA_W), .OFF_W(OFF_W), .PSEL_W(PSEL_W)) u_arr (
    .clk(clk), .commit(commit_w), .commit_row(commit_row),
    .lat_data(lat_data), .lat_valid(lat_valid),
    .rd_index(s_addr[PSEL_W+OFF_W-1:0]), .rd_data(arr_data)
  );

  // Polling: the in-flight byte answers with its top bit inverted.
  assign poll_hit = busy_w && (s_addr == last_addr);
  assign dout     = poll_hit ? poll_view(last_data) : arr_data;
  assign dout_en  = rd_level;
  assign ready    = !busy_w;

endmodule

// File: rtl/nvm_page_writer_chk.sv
module nvm_page_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic hw_rst_n,
  input logic cs_n,
  input logic oe_n,
  input logic we_n,
  input logic dout_en,
  input logic ready,
  input logic loading,
  input logic wr_accept,
  input logic commit
);

  // R2
  read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> ($past(hw_rst_n) && !$past(cs_n) && !$past(oe_n) && $past(we_n)));

  // R9
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> ready);

  // R10
  hw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> $past(hw_rst_n));

  // R4
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(loading));

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !commit) |=> !ready);

  // R7
  commit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> ready);

endmodule

bind nvm_page_writer nvm_page_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n),
  .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
  .dout_en(dout_en), .ready(ready),
  .loading(loading_w), .wr_accept(accept_w), .commit(commit_w)
);

// File: tb/test_nvm_page_writer.sv
`timescale 1ns/1ps
module test_nvm_page_writer;

  localparam int WIN  = 24;
  localparam int PROG = 80;
  localparam int PROT = 16;

  typedef struct packed {
    logic [1:0]  op;   // 0 write, 1 read and compare, 2 await programming
    logic [16:0] a;
    logic [7:0]  d;    // write data or expected read data
  } vec_t;

  // Page 3 (base 0x180) was filled with (i*7+1) beforehand.
  localparam vec_t TBL [8] = '{
    '{2'd0, 17'h00185, 8'h3C},
    '{2'd0, 17'h001A0, 8'hC1},
    '{2'd0, 17'h00185, 8'h99},
    '{2'd2, 17'h00000, 8'h00},
    '{2'd1, 17'h00185, 8'h99},
    '{2'd1, 17'h001A0, 8'hC1},
    '{2'd1, 17'h00186, 8'h2B},
    '{2'd1, 17'h00184, 8'h1D}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_rst_n = 1'b1;
  logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en, ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  nvm_page_writer #(
    .WINDOW_CYC(WIN), .PROG_CYC(PROG), .PROTECT_CYC(PROT)
  ) i_nvm_page_writer (
    .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n),
    .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .ready(ready)
  );

  function automatic logic [7:0] fill_val(input int i);
    return 8'((i * 7 + 1) & 255);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    addr = a; din = d; oe_n = 1'b1; cs_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [16:0] a, output logic [7:0] d, output logic en);
    addr = a; we_n = 1'b1; cs_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    d = dout; en = dout_en;
    cs_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [16:0] a, input logic [7:0] exp);
    logic [7:0] d;
    logic en;
    rd(a, d, en);
    check({tag, " enable"}, {31'd0, en}, 32'd1);
    check(tag, {24'd0, d}, {24'd0, exp});
  endtask

  task automatic skip(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Waits for programming and optionally checks its length in cycles.
  task automatic await_prog(input bit chk_len, input string tag);
    int t = 0;
    int n = 0;
    while (ready === 1'b1 && t < WIN + 40) begin @(negedge clk); t++; end
    if (ready !== 1'b0) begin
      check({tag, " busy start"}, {31'd0, ready}, 32'd0);
    end else begin
      while (ready === 1'b0 && n < PROG + 40) begin n++; @(negedge clk); end
      if (chk_len) check({tag, " busy length"}, n, PROG);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic en;
    skip(4);
    rst_n = 1'b1;
    skip(1);
    // R1 reset state
    check("R1 ready after reset", {31'd0, ready}, 32'd1);
    check("R1 dout_en after reset", {31'd0, dout_en}, 32'd0);
    skip(WIN + 10);
    check("R1 no load open", {31'd0, ready}, 32'd1);

    // R4 R7 full page fill, then readback
    for (int i = 0; i < 128; i++) wr(17'h180 + 17'(i), fill_val(i));
    await_prog(1'b1, "R4 128 bytes");
    for (int i = 0; i < 128; i++) rd_chk("R7 fill readback", 17'h180 + 17'(i), fill_val(i));

    // R7 table walk: overwrite within a load, untouched offsets kept
    for (int k = 0; k < 8; k++) begin
      case (TBL[k].op)
        2'd0: wr(TBL[k].a, TBL[k].d);
        2'd1: rd_chk("R7 table", TBL[k].a, TBL[k].d);
        default: await_prog(1'b1, "R4 two bytes");
      endcase
    end

    // R5 retriggered window
    wr(17'h181, 8'h11);
    skip(WIN - 6);
    check("R5 ready during window", {31'd0, ready}, 32'd1);
    wr(17'h182, 8'h22);
    skip(WIN - 6);
    check("R5 window restarted", {31'd0, ready}, 32'd1);
    skip(12);
    check("R5 programming after window", {31'd0, ready}, 32'd0);
    // R8 polling during busy
    rd_chk("R8 poll last byte", 17'h182, 8'hA2);
    rd_chk("R8 other address", 17'h183, fill_val(3));
    // R9 write while busy
    wr(17'h180, 8'hEE);
    await_prog(1'b0, "R9");
    rd_chk("R8 true data after busy", 17'h182, 8'h22);
    rd_chk("R9 busy write ignored", 17'h180, fill_val(0));
    wr(17'h18A, 8'h5A);
    await_prog(1'b1, "R4 one byte");
    rd_chk("R9 latch untouched", 17'h180, fill_val(0));
    rd_chk("R7 single byte", 17'h18A, 8'h5A);

    // R6 page lock
    wr(17'h289, 8'h10);
    await_prog(1'b0, "R6 preload");
    wr(17'h189, 8'h44);
    skip(WIN - 8);
    wr(17'h289, 8'h77);
    skip(12);
    check("R6 foreign page no restart", {31'd0, ready}, 32'd0);
    await_prog(1'b0, "R6");
    rd_chk("R6 foreign page dropped", 17'h289, 8'h10);
    rd_chk("R6 locked page written", 17'h189, 8'h44);

    // R3 capture points: address at overlap start, data at overlap end
    addr = 17'h18C; din = 8'h12; oe_n = 1'b1; cs_n = 1'b0; we_n = 1'b1;
    @(negedge clk); we_n = 1'b0;
    @(negedge clk); addr = 17'h18D; din = 8'h34;
    @(negedge clk); din = 8'h56;
    @(negedge clk); cs_n = 1'b1; din = 8'h99;
    @(negedge clk); we_n = 1'b1;
    await_prog(1'b0, "R3");
    rd_chk("R3 data at overlap end", 17'h18C, 8'h56);
    rd_chk("R3 address at overlap start", 17'h18D, fill_val(13));
    // R3 output enable low inhibits
    addr = 17'h18E; din = 8'hAB; oe_n = 1'b0; cs_n = 1'b0; we_n = 1'b0;
    skip(2);
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    skip(WIN + 10);
    check("R3 inhibited no load", {31'd0, ready}, 32'd1);
    rd_chk("R3 inhibited no data", 17'h18E, fill_val(14));

    // R2 read gating
    addr = 17'h180; cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    check("R2 oe high no drive", {31'd0, dout_en}, 32'd0);
    cs_n = 1'b1; oe_n = 1'b0;
    @(negedge clk);
    check("R2 cs high no drive", {31'd0, dout_en}, 32'd0);
    oe_n = 1'b1;
    @(negedge clk);

    // R10 external reset input and guard interval
    hw_rst_n = 1'b0;
    skip(1);
    rd(17'h180, d, en);
    check("R10 float while low", {31'd0, en}, 32'd0);
    wr(17'h18F, 8'h01);
    hw_rst_n = 1'b1;
    wr(17'h18F, 8'h02);
    skip(WIN + 10);
    check("R10 guarded writes rejected", {31'd0, ready}, 32'd1);
    rd_chk("R10 data kept", 17'h18F, fill_val(15));
    skip(PROT);
    wr(17'h18F, 8'h03);
    await_prog(1'b0, "R10");
    rd_chk("R10 write after guard", 17'h18F, 8'h03);
    wr(17'h190, 8'h04);
    hw_rst_n = 1'b0;
    skip(3);
    hw_rst_n = 1'b1;
    skip(WIN + PROT + 10);
    check("R10 load discarded", {31'd0, ready}, 32'd1);
    rd_chk("R10 discarded byte", 17'h190, fill_val(16));

    // R11 row aliasing: page 11 lands on row 3
    wr(17'h580, 8'h5F);
    await_prog(1'b0, "R11");
    rd_chk("R11 alias row", 17'h180, 8'h5F);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule